// File: doc/BRIEF.md
# Backlight Pulse-Width Generator

The block drives one pulse-width-modulated line that sets the brightness of a display backlight. It runs from a single reference clock. A fixed divide-by-16 prescaler produces a tick. A programmable counter groups N+1 ticks into one slot. Sixty-four slots make one output period. The output is high at the start of each period and stays high for D+1 slots. The output is therefore never at zero duty while it runs. D = 63 holds the line high all the time.

Software controls the block through a small synchronous register port. That port holds an enable bit, the slot length value N and the duty value D. New N and D values are kept in holding copies. The counters pick them up only when the next period begins, so a change made during a period never cuts a pulse short or stretches it. While the enable bit is clear, the line is low and every counter is held at zero.

Top module: `bl_pwm`

## Requirements
- R1: After reset the enable bit reads 0, N reads 0x2A, D reads 0x25 and `pwm_out` is low.
- R2: Registers are at these offsets: offset 0 holds the enable flag in bit 0, offset 2 holds N in bits 7:0, and offset 4 holds D in bits 5:0. A read returns the stored value with the unused upper bits zero.
- R3: A read from any other offset returns 0. A write to any other offset changes no register and does not disturb the output.
- R4: One output period lasts 1024 × (N+1) clock cycles, measured from one rising edge of `pwm_out` to the next.
- R5: Within a period `pwm_out` is high for 16 × (N+1) × (D+1) cycles. With D = 63 it stays high without interruption.
- R6: Each period starts with `pwm_out` rising. It falls only when the slot index moves past D.
- R7: `pwm_out` first rises 16 cycles after the clock edge that stores enable = 1.
- R8: `pwm_out` is low from the second clock edge after the edge that stores enable = 0. It stays low while the block is disabled, and the next enable restarts timing from zero.
- R9: A write to N or D during a period leaves that period's timing unchanged. The new value takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | Backlight drive output |

## Verification
Read data depends only on `reg_addr` and the stored registers, so the bench compares it half a cycle after the address is driven. A write becomes visible on a read in the next cycle. The first rising edge after enable is due at the 16th clock edge after the edge that stores enable. The bench counts falling edges from the write to the rise and expects exactly 17. Disable takes one more edge to reach the output, so the line is checked two falling edges after the write. Period and high time are taken from a free-running cycle counter, sampled on falling edges at each edge of `pwm_out`. The bench then compares them with 1024(N+1) and 16(N+1)(D+1). For holding-copy changes, it measures the period in which the write was made and the period after it separately.

// File: rtl/bl_pwm_pkg.sv
// Package: shared register offsets and reset values for the backlight PWM.
// Assumes offsets fit the address width chosen at the top level.
package bl_pwm_pkg;
    localparam int OFS_ENABLE = 0;
    localparam int OFS_LENGTH = 2;
    localparam int OFS_DUTY   = 4;
    localparam logic [7:0] DEF_LENGTH = 8'h2A;
    localparam logic [5:0] DEF_DUTY   = 6'h25;
endpackage

// File: rtl/bl_pwm_modcnt.sv
// Module: modulo counter with synchronous clear.
// The counter advances on adv, wraps to zero after reaching limit, and
// pulses wrap in the cycle where it advances from limit. clr wins over adv.
module bl_pwm_modcnt #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [WIDTH-1:0] limit,
    output logic [WIDTH-1:0] count,
    output logic             wrap
);
    // Terminal pulse: advancing while sitting on the limit.
    assign wrap = adv && (count == limit);

    // Count state: clear, wrap or increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (adv) begin
            count <= (count == limit) ? '0 : count + WIDTH'(1);
        end
    end
endmodule

// File: rtl/bl_pwm_regs.sv
// Module: register port for the backlight PWM.
// Holds the enable flag and the holding copies of slot length and duty.
// Reads are combinational; unmapped offsets read zero, writes there are dropped.
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int DUTY_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              enable,
    output logic [LEN_W-1:0]  hold_len,
    output logic [DUTY_W-1:0] hold_duty
);
    logic sel_en, sel_len, sel_duty;

    // Offset decode.
    assign sel_en   = (addr == ADDR_W'(OFS_ENABLE));
    assign sel_len  = (addr == ADDR_W'(OFS_LENGTH));
    assign sel_duty = (addr == ADDR_W'(OFS_DUTY));

    // Register storage with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable    <= 1'b0;
            hold_len  <= LEN_W'(DEF_LENGTH);
            hold_duty <= DUTY_W'(DEF_DUTY);
        end else if (wr) begin
            if (sel_en)   enable    <= wdata[0];
            if (sel_len)  hold_len  <= wdata[LEN_W-1:0];
            if (sel_duty) hold_duty <= wdata[DUTY_W-1:0];
        end
    end

    // Read mux, upper bits zero-filled.
    always_comb begin
        rdata = '0;
        if (sel_en)        rdata = DATA_W'(enable);
        else if (sel_len)  rdata = DATA_W'(hold_len);
        else if (sel_duty) rdata = DATA_W'(hold_duty);
    end
endmodule

// File: rtl/bl_pwm.sv
// Module: backlight PWM generator (top).
// A prescaler makes a tick every PRESCALE cycles. The slot-length counter
// groups N+1 ticks into a slot, and the slot index counts 2**SLOT_W slots per
// period. The output is high from period start through slot D. Assumes a
// single clock domain; N and D are sampled into active copies at period start.
module bl_pwm #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 8,
    parameter int SLOT_W   = 6,
    parameter int PRESCALE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'((1 << SLOT_W) - 1);

    logic              en_q;
    logic [LEN_W-1:0]  hold_len, act_len, len_cnt;
    logic [SLOT_W-1:0] hold_duty, act_duty, slot_idx;
    logic [PRE_W-1:0]  pre_cnt;
    logic              tick, running, len_wrap, period_end, start_now;

    bl_pwm_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .DUTY_W(SLOT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .rdata(reg_rdata), .enable(en_q),
        .hold_len(hold_len), .hold_duty(hold_duty)
    );

    // Fixed prescaler: one tick per PRESCALE enabled cycles.
    bl_pwm_modcnt #(.WIDTH(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(!en_q), .adv(en_q),
        .limit(PRE_W'(PRESCALE - 1)), .count(pre_cnt), .wrap(tick)
    );

    // Slot length: N+1 ticks per slot, only once a period is running.
    bl_pwm_modcnt #(.WIDTH(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .clr(!en_q), .adv(tick && running),
        .limit(act_len), .count(len_cnt), .wrap(len_wrap)
    );

    // Slot index: advances at each slot end, wraps at period end.
    bl_pwm_modcnt #(.WIDTH(SLOT_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .clr(!en_q), .adv(len_wrap),
        .limit(SLOT_LAST), .count(slot_idx), .wrap(period_end)
    );

    assign start_now = tick && !running;

    // Period control: run flag, active copies and output level.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) begin
            running  <= 1'b0;
            pwm_out  <= 1'b0;
            act_len  <= '0;
            act_duty <= '0;
        end else if (start_now || period_end) begin
            running  <= 1'b1;
            pwm_out  <= 1'b1;
            act_len  <= hold_len;
            act_duty <= hold_duty;
        end else if (len_wrap) begin
            pwm_out  <= (slot_idx < act_duty);
        end
    end
endmodule

// File: rtl/bl_pwm_chk.sv
// Module: assertion checker bound to bl_pwm.
// Watches the run flag, counters and output for the timing rules.
module bl_pwm_chk #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 8,
    parameter int SLOT_W   = 6,
    parameter int PRE_W    = 4,
    parameter int PRESCALE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_q,
    input logic              running,
    input logic [PRE_W-1:0]  pre_cnt,
    input logic [LEN_W-1:0]  len_cnt,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [SLOT_W-1:0] act_duty,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              pwm_out
);
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !pwm_out); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != 0 && reg_addr != 2 && reg_addr != 4) |-> reg_rdata == '0); // R3
    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (slot_idx == '0 && len_cnt == '0)); // R6
    AST_FALL_PAST_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_out) && en_q) |-> (slot_idx == act_duty + SLOT_W'(1))); // R6
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(running) && !$stable(act_duty)) |-> (slot_idx == '0 && len_cnt == '0)); // R9
    AST_FIRST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(pre_cnt) == PRE_W'(PRESCALE - 1))); // R7
endmodule

bind bl_pwm bl_pwm_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W),
    .PRE_W(PRE_W), .PRESCALE(PRESCALE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .running(running),
    .pre_cnt(pre_cnt), .len_cnt(len_cnt), .slot_idx(slot_idx),
    .act_duty(act_duty), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
);

// File: tb/bl_pwm_test.sv
// Bench: directed corners plus seeded random (N, D) pairs for bl_pwm.
module bl_pwm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pwm_out;
    int         errors = 0, checks = 0, cyc = 0;
    bit         done = 1'b0;

    bl_pwm uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_period(int n);
        return 1024 * (n + 1);
    endfunction
    function automatic int exp_high(int n, int d);
        return 16 * (n + 1) * (d + 1);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one write on a falling edge; returns at the next falling edge.
    task automatic wr(int a, int d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(string tag, int a, int exp);
        @(negedge clk);
        reg_addr = 3'(a);
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic wait_level(bit lvl, output int t);
        int guard = 0;
        while (pwm_out !== lvl && guard < 300000) begin
            @(negedge clk); guard++;
        end
        t = cyc;
    endtask

    // Measure high time and period starting from the next rising edge.
    task automatic measure(output int hi, output int per);
        int t0, t1, t2;
        wait_level(1'b0, t0);
        wait_level(1'b1, t0);
        wait_level(1'b0, t1);
        wait_level(1'b1, t2);
        hi = t1 - t0; per = t2 - t0;
    endtask

    task automatic run_pair(int n, int d, string tag);
        int hi, per;
        wr(0, 0); wr(2, n); wr(4, d); wr(0, 1);
        measure(hi, per);
        chk({tag, " R4 period"}, per, exp_period(n));
        chk({tag, " R5 high"}, hi, exp_high(n, d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, t3, cnt, lows;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pwm_out", int'(pwm_out), 0);
        rd("R1 enable", 0, 0);
        rd("R1 length", 2, 8'h2A);
        rd("R1 duty", 4, 8'h25);
        // R2 write/read with upper bits masked
        wr(2, 8'hC3); rd("R2 length", 2, 8'hC3);
        wr(4, 8'hFF); rd("R2 duty masked", 4, 8'h3F);
        wr(0, 8'hFE); rd("R2 enable bit0", 0, 0);
        // R3 unmapped offsets
        wr(1, 8'h55); wr(3, 8'hAA); wr(6, 8'h77);
        rd("R3 read 1", 1, 0); rd("R3 read 7", 7, 0);
        rd("R3 length kept", 2, 8'hC3); rd("R3 duty kept", 4, 8'h3F);
        chk("R3 output idle", int'(pwm_out), 0);
        // R7 first rise timing with N=0, D=0
        wr(2, 0); wr(4, 0); wr(0, 1);
        cnt = 1;
        while (!pwm_out && cnt < 100) begin @(negedge clk); cnt++; end
        chk("R7 first rise falling-edge count", cnt, 17);
        // R5 D=0 with N=0 minimum case
        run_pair(0, 0, "N0 D0");
        // R3 unmapped write while running does not disturb timing
        wr(0, 0); wr(2, 1); wr(4, 7); wr(0, 1);
        wait_level(1'b1, t0);
        wr(5, 8'h00);
        wait_level(1'b0, t1); wait_level(1'b1, t2);
        chk("R3 unmapped write high", t1 - t0, exp_high(1, 7));
        chk("R3 unmapped write period", t2 - t0, exp_period(1));
        // R5 D=63 constant high
        wr(0, 0); wr(2, 0); wr(4, 63); wr(0, 1);
        wait_level(1'b1, t0);
        lows = 0;
        repeat (3000) begin @(negedge clk); if (!pwm_out) lows++; end
        chk("R5 D63 low samples", lows, 0);
        // R8 disable
        wr(0, 0);
        @(negedge clk);
        chk("R8 low after disable", int'(pwm_out), 0);
        lows = 0;
        repeat (2000) begin @(negedge clk); if (pwm_out) lows++; end
        chk("R8 stays low", lows, 0);
        // R8 re-enable restarts from zero
        wr(0, 1);
        cnt = 1;
        while (!pwm_out && cnt < 100) begin @(negedge clk); cnt++; end
        chk("R8 restart rise count", cnt, 17);
        // R9 duty change mid-period
        wr(0, 0); wr(2, 0); wr(4, 10); wr(0, 1);
        wait_level(1'b1, t0);
        wr(4, 40);
        wait_level(1'b0, t1); wait_level(1'b1, t2); wait_level(1'b0, t3);
        chk("R9 old duty kept", t1 - t0, exp_high(0, 10));
        chk("R9 new duty next", t3 - t2, exp_high(0, 40));
        // R9 length change mid-period
        wr(0, 0); wr(2, 0); wr(4, 5); wr(0, 1);
        wait_level(1'b1, t0);
        wr(2, 1);
        wait_level(1'b0, t1); wait_level(1'b1, t1);
        wait_level(1'b0, t2); wait_level(1'b1, t2);
        chk("R9 old length kept", t1 - t0, exp_period(0));
        chk("R9 new length next", t2 - t1, exp_period(1));
        // R4 R5 R6 random pairs
        for (int i = 0; i < 4; i++) begin
            int n = int'($urandom_range(0, 2));
            int d = int'($urandom_range(0, 62));
            run_pair(n, d, "random");
        end
        run_pair(2, 62, "N2 D62");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule